// File: doc/BRIEF.md
# Eight-bit single-cycle processor core

This block is a small processor that completes one instruction per clock. Each cycle it does the following:

- Reads a 21-bit instruction word from a 256-word instruction array, at the address held in an 8-bit program counter.
- Picks two 8-bit operands out of an eight-entry register file.
- Computes a result in an adder/logic unit.
- Writes the result back to the register file at the same edge that advances the program counter.

The instruction array is filled through a simple write port, normally while the core is held in reset. The program counter and all eight registers are brought out as outputs, and they are the visible result of a program.

Two stop conditions exist.

- **Halt.** Architectural state is frozen, but the program counter keeps stepping and wraps around.
- **Fire.** The program counter itself is stopped on the stopping instruction. This applies even when the core is already halted.

Both conditions end only at reset.

Top module: `cpu8_core`

## Requirements
- R1: An instruction word holds the opcode in bits 20..17, the destination index in 16..14, the first source index in 13..11, the second source index in 10..8 and an unsigned 8-bit constant in 7..0. A writing instruction updates the destination register at the clock edge that ends its cycle.
- R2: The program counter starts at 0, rises by one per cycle, wraps from 255 to 0, and selects the instruction word executed in that cycle.
- R3: Register-to-register opcodes, all modulo 256:
  - 0001: bitwise inverse of source 1.
  - 0010: AND.
  - 0011: XOR.
  - 0100: OR.
  - 0101: source 1 plus source 2.
  - 0110: source 1 minus source 2.
  - 0111: copy of source 1.
- R4: Opcodes that take the constant instead of source 2:
  - 1000: loads the constant.
  - 1001: adds the constant to source 1, modulo 256.
  - 1010: subtracts the constant from source 1, modulo 256.
- R5: Opcode 1011 shifts source 1 left by one and fills a zero. Opcode 1100 shifts it right by one and fills a zero. Opcode 1101 writes 1 when source 1 equals source 2 and 0 otherwise.
- R6: Opcode 0000 changes no register; only the program counter moves.
- R7: After an instruction with opcode 1110 executes, no register changes until reset. The program counter keeps stepping and wraps.
- R8: When an instruction with opcode 1111 executes, the program counter stays at that instruction's address from then on. No register changes until reset.
- R9: An opcode 1111 reached while halted still stops the program counter at its address.
- R10: A synchronous active-low reset returns the program counter, all registers, and both stop conditions to 0 / clear.
- R11: When the load enable is high at a clock edge, the load word is written into the instruction array at the load address. A program reaching that address executes the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Instruction array write enable |
| ld_addr | input | 8 | Instruction array write address |
| ld_word | input | 21 | Instruction word to store |
| pc | output | 8 | Current program counter |
| regs_flat | output | 64 | All registers; register k occupies bits 8k+7..8k |

## Verification
Every register is an output, so a wrong write shows on the ports one edge after the faulty instruction. This covers a bad operand select, a bad immediate select, a missing write gate or a carry error.

Wrong stop state shows in the same way:
- A stop flag that sets late, or never sets, makes a register change after halt, or the counter move after fire, in the very next cycle.
- A flag that sets spuriously freezes a register that should have been written.

The bench compares the counter and all eight registers every cycle with a behavioural model. A divergence is therefore caught within one cycle of its cause.

// File: rtl/cpu8_pkg.sv
// Shared constants and opcode encoding for the eight-bit single-cycle core.
// Assumes the instruction layout: opcode, destination, source 1, source 2,
// constant, from most to least significant bits.
package cpu8_pkg;

    localparam int OPW  = 4;   // opcode field width
    localparam int RIDX = 3;   // register index field width
    localparam int DATW = 8;   // datapath width

    typedef enum logic [OPW-1:0] {
        OP_NOP  = 4'h0,
        OP_INV  = 4'h1,
        OP_AND  = 4'h2,
        OP_XOR  = 4'h3,
        OP_OR   = 4'h4,
        OP_ADD  = 4'h5,
        OP_SUB  = 4'h6,
        OP_MOV  = 4'h7,
        OP_LDI  = 4'h8,
        OP_ADDI = 4'h9,
        OP_SUBI = 4'hA,
        OP_SHL  = 4'hB,
        OP_SHR  = 4'hC,
        OP_EQ   = 4'hD,
        OP_HALT = 4'hE,
        OP_FIRE = 4'hF
    } opcode_e;

endpackage

// File: rtl/cpu8_fetch.sv
// Program counter and instruction array.
// The counter steps by one each cycle unless hold is high, and wraps.
// The array has one write port (ld_*) and an asynchronous read at the counter.
// Assumes the array is loaded before it is executed; it has no reset.
module cpu8_fetch #(
    parameter int AW = 8,
    parameter int IW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [IW-1:0] ld_word,
    output logic [AW-1:0] pc,
    output logic [IW-1:0] instr
);
    localparam int DEPTH = 1 << AW;

    logic [IW-1:0] mem [DEPTH];
    logic [AW-1:0] pc_q;

    // Store a word into the instruction array.
    always_ff @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_word;
    end

    // Advance or hold the program counter.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (!hold) pc_q <= pc_q + 1'b1;
    end

    assign pc    = pc_q;
    assign instr = mem[pc_q];

endmodule

// File: rtl/cpu8_regs.sv
// Register file with one write port and two asynchronous read ports.
// Every register is also exposed on a flat bus; entry k sits at bits k*W.
// Assumes N is a power of two, so every index value names a register.
module cpu8_regs #(
    parameter int W    = 8,
    parameter int N    = 8,
    parameter int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] waddr,
    input  logic [W-1:0]    wdata,
    input  logic [IDXW-1:0] ra,
    input  logic [IDXW-1:0] rb,
    output logic [W-1:0]    a_data,
    output logic [W-1:0]    b_data,
    output logic [N*W-1:0]  flat
);
    logic [W-1:0] q [N];

    for (genvar r = 0; r < N; r++) begin : g_reg
        // Load register r when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)                        q[r] <= '0;
            else if (we && waddr == IDXW'(r))  q[r] <= wdata;
        end
        assign flat[r*W +: W] = q[r];
    end

    assign a_data = q[ra];
    assign b_data = q[rb];

endmodule

// File: rtl/cpu8_alu.sv
// Combinational arithmetic/logic unit.
// Add and subtract use carry lookahead inside GRP-bit groups; each group
// forms all of its carries from its own carry-in, and groups chain their
// carries from one to the next. Subtract adds the inverted operand plus one.
// Assumes W is a multiple of GRP.
module cpu8_alu
    import cpu8_pkg::*;
#(
    parameter int W   = 8,
    parameter int GRP = 4
) (
    input  opcode_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int NGRP = W / GRP;

    logic         sub;
    logic [W-1:0] bx, p, g, sum;
    logic [W:0]   carry;

    assign sub      = (op == OP_SUB) || (op == OP_SUBI);
    assign bx       = sub ? ~b : b;
    assign p        = a ^ bx;
    assign g        = a & bx;
    assign carry[0] = sub;

    for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
        localparam int BASE = gi * GRP;
        for (genvar bi = 1; bi <= GRP; bi++) begin : g_bit
            logic cbit;
            // Flattened lookahead term for carry into bit BASE+bi.
            always_comb begin
                logic acc;
                logic run;
                acc = 1'b0;
                for (int j = 0; j < bi; j++) begin
                    run = g[BASE+j];
                    for (int k = j + 1; k < bi; k++) run = run & p[BASE+k];
                    acc = acc | run;
                end
                run = carry[BASE];
                for (int k = 0; k < bi; k++) run = run & p[BASE+k];
                cbit = acc | run;
            end
            assign carry[BASE+bi] = cbit;
        end
    end

    assign sum = p ^ carry[W-1:0];

    // Select the result by opcode.
    always_comb begin
        unique case (op)
            OP_INV:                  y = ~a;
            OP_AND:                  y = a & b;
            OP_XOR:                  y = a ^ b;
            OP_OR:                   y = a | b;
            OP_ADD,  OP_SUB,
            OP_ADDI, OP_SUBI:        y = sum;
            OP_MOV:                  y = a;
            OP_LDI:                  y = b;
            OP_SHL:                  y = {a[W-2:0], 1'b0};
            OP_SHR:                  y = {1'b0, a[W-1:1]};
            OP_EQ:                   y = W'(a == b);
            default:                 y = '0;
        endcase
    end

endmodule

// File: rtl/cpu8_ctrl.sv
// Decode and stop-state control.
// Produces the register write enable, the constant-operand select and the
// program counter hold, and keeps the sticky halt and fire flags.
// Assumes the opcode comes from the instruction executed this cycle.
module cpu8_ctrl
    import cpu8_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_e op,
    output logic    wen,
    output logic    use_imm,
    output logic    hold_pc,
    output logic    halted,
    output logic    fire
);
    logic writes;

    assign writes  = !(op inside {OP_NOP, OP_HALT, OP_FIRE});
    assign wen     = writes && !halted && !fire;
    assign use_imm = op inside {OP_LDI, OP_ADDI, OP_SUBI};
    assign hold_pc = fire || (op == OP_FIRE);

    // Set the sticky stop flags; only reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
            fire   <= 1'b0;
        end else begin
            if (op == OP_HALT) halted <= 1'b1;
            if (op == OP_FIRE) fire   <= 1'b1;
        end
    end

endmodule

// File: rtl/cpu8_core.sv
// Eight-bit single-cycle processor core: fetch, decode, operand select,
// execute and write back, all in one clock.
// Assumes the instruction array is loaded through ld_* before reset is
// released. The register index width is fixed by the instruction layout.
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter int XLEN    = DATW,
    parameter int PC_BITS = 8,
    parameter int CLA_GRP = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_en,
    input  logic [PC_BITS-1:0]         ld_addr,
    input  logic [OPW+3*RIDX+XLEN-1:0] ld_word,
    output logic [PC_BITS-1:0]         pc,
    output logic [(1<<RIDX)*XLEN-1:0]  regs_flat
);
    localparam int NREG   = 1 << RIDX;
    localparam int IW     = OPW + 3*RIDX + XLEN;
    localparam int RS2_LO = XLEN;
    localparam int RS1_LO = RS2_LO + RIDX;
    localparam int RD_LO  = RS1_LO + RIDX;
    localparam int OP_LO  = RD_LO + RIDX;

    logic [IW-1:0]   instr;
    opcode_e         op;
    logic [RIDX-1:0] rd, rs1, rs2;
    logic [XLEN-1:0] imm, a_val, rb_val, b_val, alu_y;
    logic            wen, use_imm, hold_pc, halted_q, fire_q;

    assign op  = opcode_e'(instr[OP_LO +: OPW]);
    assign rd  = instr[RD_LO  +: RIDX];
    assign rs1 = instr[RS1_LO +: RIDX];
    assign rs2 = instr[RS2_LO +: RIDX];
    assign imm = instr[XLEN-1:0];

    cpu8_fetch #(.AW(PC_BITS), .IW(IW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .hold(hold_pc),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_word(ld_word),
        .pc(pc), .instr(instr)
    );

    cpu8_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .op(op),
        .wen(wen), .use_imm(use_imm), .hold_pc(hold_pc),
        .halted(halted_q), .fire(fire_q)
    );

    cpu8_regs #(.W(XLEN), .N(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(wen), .waddr(rd), .wdata(alu_y),
        .ra(rs1), .rb(rs2), .a_data(a_val), .b_data(rb_val), .flat(regs_flat)
    );

    assign b_val = use_imm ? imm : rb_val;

    cpu8_alu #(.W(XLEN), .GRP(CLA_GRP)) u_alu (
        .op(op), .a(a_val), .b(b_val), .y(alu_y)
    );

endmodule

// File: rtl/cpu8_core_chk.sv
// Temporal checks on the core's counter, registers and stop flags.
// Attached to every cpu8_core instance by the bind below.
module cpu8_core_chk #(
    parameter int PCW = 8,
    parameter int RW  = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic [3:0]     op,
    input logic [PCW-1:0] pc,
    input logic [RW-1:0]  regs,
    input logic           halted,
    input logic           fire
);
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && regs == '0));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && op != 4'hF) |=> pc == PCW'($past(pc) + 1'b1));

    assert_nop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'h0) |=> $stable(regs));

    assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(regs)));

    assert_fire_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'hF) |=> (fire && $stable(pc) && $stable(regs)));

    assert_fire_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (fire && $stable(pc) && $stable(regs)));

    assert_fire_after_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && op == 4'hF) |=> (fire && $stable(pc)));

endmodule

bind cpu8_core cpu8_core_chk #(.PCW(PC_BITS), .RW(NREG*XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .op(instr[OP_LO +: 4]), .pc(pc),
    .regs(regs_flat), .halted(halted_q), .fire(fire_q)
);

// File: tb/cpu8_core_test.sv
`timescale 1ns/1ps
module cpu8_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [20:0] ld_word = '0;
    logic [7:0]  pc;
    logic [63:0] regs_flat;

    int checks = 0;
    int fails  = 0;

    // Behavioural model state
    logic [20:0] m_mem [256];
    logic [7:0]  m_x [8];
    logic [7:0]  m_pc;
    logic        m_halt, m_fire;
    logic [20:0] prog [256];

    cpu8_core uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_word(ld_word), .pc(pc), .regs_flat(regs_flat)
    );

    always #5 clk = ~clk;

    function automatic logic [20:0] enc(input logic [3:0] op, input logic [2:0] rd,
            input logic [2:0] s1, input logic [2:0] s2, input logic [7:0] imm);
        return {op, rd, s1, s2, imm};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = '0; m_halt = 1'b0; m_fire = 1'b0;
        for (int i = 0; i < 8; i++) m_x[i] = '0;
    endtask

    // One cycle of the model, from the requirements
    task automatic model_step();
        logic [20:0] w;
        logic [3:0]  op;
        logic [7:0]  a, b, r;
        w  = m_mem[m_pc];
        op = w[20:17];
        a  = m_x[w[13:11]];
        b  = (op == 4'h8 || op == 4'h9 || op == 4'hA) ? w[7:0] : m_x[w[10:8]];
        case (op)
            4'h1: r = ~a;
            4'h2: r = a & b;
            4'h3: r = a ^ b;
            4'h4: r = a | b;
            4'h5, 4'h9: r = a + b;
            4'h6, 4'hA: r = a - b;
            4'h7: r = a;
            4'h8: r = b;
            4'hB: r = a << 1;
            4'hC: r = a >> 1;
            4'hD: r = (a == b) ? 8'd1 : 8'd0;
            default: r = '0;
        endcase
        if (m_fire) begin
            // frozen
        end else if (op == 4'hF) begin
            m_fire = 1'b1;
        end else begin
            if (!m_halt && op != 4'h0 && op != 4'hE) m_x[w[16:14]] = r;
            if (op == 4'hE) m_halt = 1'b1;
            m_pc = m_pc + 1'b1;
        end
    endtask

    // Compare at the current negedge, advance the model, wait one cycle
    task automatic run(input int n, input string rtag, input string ptag);
        for (int c = 0; c < n; c++) begin
            check(ptag, "pc", pc, m_pc);
            for (int k = 0; k < 8; k++)
                check(rtag, $sformatf("x%0d", k), regs_flat[k*8 +: 8], m_x[k]);
            model_step();
            @(negedge clk);
        end
    endtask

    // Hold reset, load prog[] through the port (R11), release reset
    task automatic load_and_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            ld_en = 1'b1; ld_addr = 8'(i); ld_word = prog[i];
            m_mem[i] = prog[i];
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = '0;
    endtask

    task automatic test_reset_state();
        clear_prog();
        load_and_reset();
        check("R10", "pc after reset", pc, 8'h00);
        for (int k = 0; k < 8; k++) check("R10", "reg after reset", regs_flat[k*8 +: 8], 8'h00);
    endtask

    task automatic test_reg_ops();   // R1, R3
        clear_prog();
        prog[0]  = enc(4'h8, 3'd1, 3'd0, 3'd0, 8'hC5);
        prog[1]  = enc(4'h8, 3'd2, 3'd0, 3'd0, 8'h3A);
        prog[2]  = enc(4'h1, 3'd3, 3'd1, 3'd0, 8'hFF);
        prog[3]  = enc(4'h2, 3'd4, 3'd1, 3'd2, 8'h00);
        prog[4]  = enc(4'h3, 3'd5, 3'd1, 3'd3, 8'h00);
        prog[5]  = enc(4'h4, 3'd6, 3'd2, 3'd1, 8'h00);
        prog[6]  = enc(4'h5, 3'd7, 3'd1, 3'd1, 8'h00);
        prog[7]  = enc(4'h6, 3'd0, 3'd2, 3'd1, 8'h00);
        prog[8]  = enc(4'h7, 3'd3, 3'd7, 3'd5, 8'h11);
        prog[9]  = enc(4'h5, 3'd4, 3'd2, 3'd1, 8'h00);
        prog[10] = enc(4'h6, 3'd5, 3'd1, 3'd1, 8'h00);
        load_and_reset();
        run(14, "R3", "R2");
        check("R3", "add wrap x7", regs_flat[63:56], 8'h8A);
        check("R1", "sub into x0", regs_flat[7:0], 8'h75);
    endtask

    task automatic test_imm_ops();   // R4
        clear_prog();
        prog[0] = enc(4'h8, 3'd1, 3'd5, 3'd6, 8'hF0);
        prog[1] = enc(4'h9, 3'd2, 3'd1, 3'd1, 8'h20);
        prog[2] = enc(4'hA, 3'd3, 3'd2, 3'd1, 8'h30);
        prog[3] = enc(4'h9, 3'd4, 3'd1, 3'd7, 8'h0F);
        prog[4] = enc(4'hA, 3'd5, 3'd1, 3'd1, 8'hF0);
        load_and_reset();
        run(7, "R4", "R2");
        check("R4", "addi wrap", regs_flat[23:16], 8'h10);
        check("R4", "subi borrow", regs_flat[31:24], 8'hE0);
    endtask

    task automatic test_shift_cmp(); // R5
        clear_prog();
        prog[0] = enc(4'h8, 3'd1, 3'd0, 3'd0, 8'h81);
        prog[1] = enc(4'hB, 3'd2, 3'd1, 3'd0, 8'h00);
        prog[2] = enc(4'hC, 3'd3, 3'd1, 3'd0, 8'h00);
        prog[3] = enc(4'hD, 3'd4, 3'd1, 3'd1, 8'h00);
        prog[4] = enc(4'hD, 3'd5, 3'd1, 3'd2, 8'h00);
        prog[5] = enc(4'h8, 3'd6, 3'd0, 3'd0, 8'h81);
        prog[6] = enc(4'hD, 3'd7, 3'd1, 3'd6, 8'h00);
        load_and_reset();
        run(9, "R5", "R2");
        check("R5", "shl", regs_flat[23:16], 8'h02);
        check("R5", "eq false", regs_flat[47:40], 8'h00);
    endtask

    task automatic test_nop_wrap();  // R6, R2 wrap
        clear_prog();
        prog[0] = enc(4'h8, 3'd2, 3'd0, 3'd0, 8'h5C);
        prog[1] = enc(4'h0, 3'd2, 3'd2, 3'd2, 8'hFF);
        load_and_reset();
        run(262, "R6", "R2");
        check("R6", "x2 kept", regs_flat[23:16], 8'h5C);
    endtask

    task automatic test_halt();      // R7
        clear_prog();
        prog[0] = enc(4'h8, 3'd1, 3'd0, 3'd0, 8'h42);
        prog[1] = enc(4'hE, 3'd0, 3'd0, 3'd0, 8'h00);
        for (int i = 2; i < 256; i++) prog[i] = enc(4'h9, 3'(i), 3'd1, 3'd1, 8'(i));
        load_and_reset();
        run(300, "R7", "R7");
        check("R7", "x1 after halt", regs_flat[15:8], 8'h42);
    endtask

    task automatic test_fire();      // R8, R10
        clear_prog();
        prog[0] = enc(4'h8, 3'd1, 3'd0, 3'd0, 8'h17);
        prog[1] = enc(4'h9, 3'd1, 3'd1, 3'd0, 8'h01);
        prog[2] = enc(4'hF, 3'd1, 3'd1, 3'd1, 8'h00);
        prog[3] = enc(4'h8, 3'd1, 3'd0, 3'd0, 8'h99);
        load_and_reset();
        run(20, "R8", "R8");
        check("R8", "pc stuck", pc, 8'h02);
        // reset without reload clears fire
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; model_reset();
        check("R10", "pc after fire reset", pc, 8'h00);
        check("R10", "x1 after fire reset", regs_flat[15:8], 8'h00);
        run(6, "R10", "R10");
    endtask

    task automatic test_halt_then_fire(); // R9
        clear_prog();
        prog[0] = enc(4'h8, 3'd3, 3'd0, 3'd0, 8'hAB);
        prog[1] = enc(4'hE, 3'd0, 3'd0, 3'd0, 8'h00);
        prog[2] = enc(4'h8, 3'd3, 3'd0, 3'd0, 8'h01);
        prog[5] = enc(4'hF, 3'd0, 3'd0, 3'd0, 8'h00);
        load_and_reset();
        run(30, "R9", "R9");
        check("R9", "pc stopped", pc, 8'h05);
        check("R9", "x3 kept", regs_flat[31:24], 8'hAB);
    endtask

    task automatic test_reload();    // R11
        clear_prog();
        prog[0] = enc(4'h8, 3'd7, 3'd0, 3'd0, 8'h5A);
        load_and_reset();
        run(5, "R11", "R2");
        ld_en = 1'b1; ld_addr = 8'd200; ld_word = enc(4'h8, 3'd6, 3'd0, 3'd0, 8'h77);
        m_mem[200] = ld_word;
        run(1, "R11", "R2");
        ld_en = 1'b0;
        run(200, "R11", "R2");
        check("R11", "x6 from new word", regs_flat[55:48], 8'h77);
        check("R11", "x7", regs_flat[63:56], 8'h5A);
    endtask

    initial begin
        #1ms;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        test_reset_state();
        test_reg_ops();
        test_imm_ops();
        test_shift_cmp();
        test_nop_wrap();
        test_halt();
        test_fire();
        test_halt_then_fire();
        test_reload();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule